// File: doc/BRIEF.md
# Function Sleep-Control Register Block

This block sits on the device side of an SDIO card, behind the command front end that turns host register accesses into single-byte reads and writes. It holds seven vendor-specific byte registers from 0xF0 to 0xF6. The first sets the function's sleep mode, which decides whether the chip may enter deep sleep, must be woken, or must be woken and then signal the host once it is up. The others are a write-one-to-clear register for that wake-up interrupt, two scratch bytes the host writes, two scratch bytes the chip writes, and an extended I/O enable byte.

The sleep mode comes from two bits of the sleep register: a wake-request bit and a ready-interrupt enable bit. With wake request clear the mode is torpid and `allow_sleep` is high. With wake request set the chip must stay awake. `wake_out` is driven while the power manager reports it is not awake. When the ready-interrupt enable bit is also set (drowsy), the next rising edge of `pm_awake` latches a host interrupt.

The extended I/O enable byte is compared with the I/O enable bits of the common register set, which come in as a port. A function whose common enable is set while its extended enable is clear has been reset from inside the chip. The host restores it by writing the extended bit again. Host accesses use a plain strobe with no back-pressure. A write takes effect at the clock edge where it is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `fn_sleep_ctrl`

## Requirements
- R1: After reset every register reads 0x00. The mode is torpid, so `allow_sleep`=1, and `host_irq`=0 and `wake_out`=0.
- R2: Register 0xF0 holds the wake request in bit 0, the ready-interrupt enable in bit 1 and a function number in bits 7:4. Bits 3:2 read 0. `allow_sleep` is 1 exactly when bit 0 is 0.
- R3: `wake_out` is 1 exactly when the wake-request bit is 1 and `pm_awake` is 0.
- R4: In drowsy mode (0xF0 low bits = 2'b11), a rising edge of `pm_awake` raises `host_irq` at the next clock edge. Register 0xF1 reads it back in bit 0. In awake mode (2'b01) a rising edge raises nothing.
- R5: A host write to 0xF1 with bit 0 = 1 drops `host_irq`, and a write with bit 0 = 0 leaves it set. Leaving drowsy mode drops `host_irq` at once and discards the pending interrupt.
- R6: Registers 0xF2 and 0xF3 store host-written bytes and read them back.
- R7: Registers 0xF4 and 0xF5 are loaded from `chip_wr_data` when `chip_wr_en` is set, with `chip_wr_sel` = 0 for 0xF4 and 1 for 0xF5. Host writes to these addresses change nothing.
- R8: Bit i+1 of 0xF6 is the extended enable of function i+1 and maps to bit i of the ports. Bit 0 reads 0. `fn_reset_flag[i]` = `cccr_io_en[i]` AND NOT extended bit i.
- R9: A pulse on `fn_rst[i]` clears extended bit i and both from-host scratch registers. The pulse takes priority over a host write in the same cycle.
- R10: Reads of any address outside 0xF0..0xF6 return 0x00. Read data appears one cycle after `host_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| host_wr_en | input | 1 | Host byte write strobe |
| host_rd_en | input | 1 | Host byte read strobe |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| chip_wr_en | input | 1 | Chip write strobe for to-host scratch |
| chip_wr_sel | input | 1 | 0 selects 0xF4, 1 selects 0xF5 |
| chip_wr_data | input | 8 | Chip scratch data |
| pm_awake | input | 1 | Power manager reports chip awake |
| cccr_io_en | input | NUM_FUNC | Common I/O enable, bit i = function i+1 |
| fn_rst | input | NUM_FUNC | Internal function reset pulses |
| allow_sleep | output | 1 | Chip may enter deep sleep |
| wake_out | output | 1 | Request to leave deep sleep |
| host_irq | output | 1 | Ready interrupt to the host |
| fn_reset_flag | output | NUM_FUNC | Function internally reset |

## Verification
The sleep function is tried with each mode written while `pm_awake` is low and while it is high. This separates the level-driven `wake_out` from the edge-driven interrupt, and shows that awake mode never interrupts while drowsy mode does. The interrupt is cleared three ways: a zero write, a one write, and a mode change. A rise that comes before drowsy is selected is also checked, which catches a level-sensitive latch. The reset-detection byte is driven with mixed common-enable patterns, with a reset pulse that collides with a host write, and with a write to the reserved bit 0.

// File: rtl/fn_sleep_pkg.sv
package fn_sleep_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_SLEEP  = 8'hF0;
  localparam logic [AW-1:0] A_ICLR   = 8'hF1;
  localparam logic [AW-1:0] A_FH0    = 8'hF2;
  localparam logic [AW-1:0] A_FH1    = 8'hF3;
  localparam logic [AW-1:0] A_TH0    = 8'hF4;
  localparam logic [AW-1:0] A_TH1    = 8'hF5;
  localparam logic [AW-1:0] A_EXTEN  = 8'hF6;

  typedef enum logic [1:0] {
    MODE_TORPID = 2'd0,
    MODE_AWAKE  = 2'd1,
    MODE_DROWSY = 2'd2
  } sleep_mode_t;

  typedef struct packed {
    logic [3:0] func;
    logic       rdy_en;
    logic       wake;
  } sleep_reg_t;
endpackage

// File: rtl/fn_sleep_regs.sv
module fn_sleep_regs
  import fn_sleep_pkg::*;
#(
  parameter int NUM_FUNC = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_en,
  input  logic                host_rd_en,
  input  logic [AW-1:0]       host_addr,
  input  logic [DW-1:0]       host_wdata,
  output logic [DW-1:0]       host_rdata,
  input  logic                chip_wr_en,
  input  logic                chip_wr_sel,
  input  logic [DW-1:0]       chip_wr_data,
  input  logic [NUM_FUNC-1:0] fn_rst,
  input  logic                irq_level,
  output sleep_reg_t          sleep_q,
  output logic                irq_clr,
  output logic [NUM_FUNC-1:0] ext_en
);
  localparam int SCR_N = 2;

  logic [DW-1:0] fh_q [SCR_N];
  logic [DW-1:0] th_q [SCR_N];
  logic          any_rst;
  logic [DW-1:0] rd_mux;

  assign any_rst = |fn_rst;
  assign irq_clr = host_wr_en && (host_addr == A_ICLR) && host_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= '0;
    end else if (host_wr_en && host_addr == A_SLEEP) begin
      sleep_q.func   <= host_wdata[7:4];
      sleep_q.rdy_en <= host_wdata[1];
      sleep_q.wake   <= host_wdata[0];
    end
  end

  genvar s;
  generate
    for (s = 0; s < SCR_N; s++) begin : g_scr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fh_q[s] <= '0;
        end else if (any_rst) begin
          fh_q[s] <= '0;
        end else if (host_wr_en && host_addr == A_FH0 + AW'(s)) begin
          fh_q[s] <= host_wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          th_q[s] <= '0;
        end else if (chip_wr_en && (int'(chip_wr_sel) == s)) begin
          th_q[s] <= chip_wr_data;
        end
      end
    end
  endgenerate

  genvar f;
  generate
    for (f = 0; f < NUM_FUNC; f++) begin : g_ext
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ext_en[f] <= 1'b0;
        end else if (fn_rst[f]) begin
          ext_en[f] <= 1'b0;
        end else if (host_wr_en && host_addr == A_EXTEN) begin
          ext_en[f] <= host_wdata[f+1];
        end
      end
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    unique case (host_addr)
      A_SLEEP: rd_mux = {sleep_q.func, 2'b00, sleep_q.rdy_en, sleep_q.wake};
      A_ICLR:  rd_mux = {{(DW-1){1'b0}}, irq_level};
      A_FH0:   rd_mux = fh_q[0];
      A_FH1:   rd_mux = fh_q[1];
      A_TH0:   rd_mux = th_q[0];
      A_TH1:   rd_mux = th_q[1];
      A_EXTEN: rd_mux = DW'({ext_en, 1'b0});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd_en) begin
      host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/fn_sleep_fsm.sv
module fn_sleep_fsm
  import fn_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sleep_reg_t sleep_q,
  input  logic       pm_awake,
  input  logic       irq_clr,
  output logic       allow_sleep,
  output logic       wake_out,
  output logic       host_irq,
  output logic       awake_rise
);
  sleep_mode_t mode;
  logic        awake_q;
  logic        pend_q;

  always_comb begin
    if (!sleep_q.wake)       mode = MODE_TORPID;
    else if (sleep_q.rdy_en) mode = MODE_DROWSY;
    else                     mode = MODE_AWAKE;
  end

  assign allow_sleep = (mode == MODE_TORPID);
  assign wake_out    = (mode != MODE_TORPID) && !pm_awake;
  assign awake_rise  = pm_awake && !awake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) awake_q <= 1'b0;
    else        awake_q <= pm_awake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (mode == MODE_DROWSY && awake_rise) begin
      pend_q <= 1'b1;
    end else if (irq_clr || mode != MODE_DROWSY) begin
      pend_q <= 1'b0;
    end
  end

  assign host_irq = pend_q && (mode == MODE_DROWSY);
endmodule

// File: rtl/fn_sleep_ctrl.sv
module fn_sleep_ctrl
  import fn_sleep_pkg::*;
#(
  parameter int NUM_FUNC = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_en,
  input  logic                host_rd_en,
  input  logic [7:0]          host_addr,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  input  logic                chip_wr_en,
  input  logic                chip_wr_sel,
  input  logic [7:0]          chip_wr_data,
  input  logic                pm_awake,
  input  logic [NUM_FUNC-1:0] cccr_io_en,
  input  logic [NUM_FUNC-1:0] fn_rst,
  output logic                allow_sleep,
  output logic                wake_out,
  output logic                host_irq,
  output logic [NUM_FUNC-1:0] fn_reset_flag
);
  sleep_reg_t          sleep_q;
  logic                irq_clr;
  logic                awake_rise;
  logic [NUM_FUNC-1:0] ext_en;

  fn_sleep_regs #(.NUM_FUNC(NUM_FUNC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .chip_wr_en(chip_wr_en), .chip_wr_sel(chip_wr_sel), .chip_wr_data(chip_wr_data),
    .fn_rst(fn_rst), .irq_level(host_irq),
    .sleep_q(sleep_q), .irq_clr(irq_clr), .ext_en(ext_en)
  );

  fn_sleep_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_q(sleep_q), .pm_awake(pm_awake),
    .irq_clr(irq_clr), .allow_sleep(allow_sleep), .wake_out(wake_out),
    .host_irq(host_irq), .awake_rise(awake_rise)
  );

  assign fn_reset_flag = cccr_io_en & ~ext_en;
endmodule

// File: rtl/fn_sleep_ctrl_chk.sv
module fn_sleep_ctrl_chk #(
  parameter int NUM_FUNC = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_wr_en,
  input logic [7:0]          host_addr,
  input logic [7:0]          host_wdata,
  input logic                pm_awake,
  input logic                awake_rise,
  input logic [NUM_FUNC-1:0] cccr_io_en,
  input logic [NUM_FUNC-1:0] fn_rst,
  input logic                allow_sleep,
  input logic                wake_out,
  input logic                host_irq,
  input logic [NUM_FUNC-1:0] fn_reset_flag
);
  // R3
  wake_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> (!pm_awake && !allow_sleep));

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_irq ##1 host_irq) |-> ($past(awake_rise) && !allow_sleep));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_addr == 8'hF1 && host_wdata[0] && !awake_rise) |=> !host_irq);

  // R5
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !allow_sleep);

  // R9
  fn_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fn_rst) |=> ((fn_reset_flag & $past(fn_rst)) == (cccr_io_en & $past(fn_rst))));
endmodule

bind fn_sleep_ctrl fn_sleep_ctrl_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
  .host_wdata(host_wdata), .pm_awake(pm_awake), .awake_rise(awake_rise),
  .cccr_io_en(cccr_io_en), .fn_rst(fn_rst), .allow_sleep(allow_sleep),
  .wake_out(wake_out), .host_irq(host_irq), .fn_reset_flag(fn_reset_flag)
);

// File: tb/sim_fn_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_fn_sleep_ctrl;
  localparam int NF = 7;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr_en = 0, host_rd_en = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, host_rdata;
  logic chip_wr_en = 0, chip_wr_sel = 0;
  logic [7:0] chip_wr_data = 0;
  logic pm_awake = 0;
  logic [NF-1:0] cccr_io_en = 0, fn_rst = 0;
  logic allow_sleep, wake_out, host_irq;
  logic [NF-1:0] fn_reset_flag;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fn_sleep_ctrl #(.NUM_FUNC(NF)) u0 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_rd_en = 1; host_addr = a;
    @(negedge clk); host_rd_en = 0; d = host_rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    for (int a = 8'hF0; a <= 8'hF6; a++) rd_chk("R1", 8'(a), 8'h00);
    check("R1 allow", {7'b0, allow_sleep}, 8'h01);
    check("R1 irq", {7'b0, host_irq}, 8'h00);
    check("R1 wake", {7'b0, wake_out}, 8'h00);
  endtask

  task automatic t_modes;
    wr(8'hF0, 8'h51);
    rd_chk("R2", 8'hF0, 8'h51);
    check("R2 allow", {7'b0, allow_sleep}, 8'h00);
    check("R3 wake", {7'b0, wake_out}, 8'h01);
    @(negedge clk); pm_awake = 1;
    @(negedge clk);
    check("R3 awake", {7'b0, wake_out}, 8'h00);
    @(negedge clk);
    check("R4 awake mode", {7'b0, host_irq}, 8'h00);
    wr(8'hF0, 8'h5E);
    rd_chk("R2 bits", 8'hF0, 8'h52);
    check("R2 torpid", {7'b0, allow_sleep}, 8'h01);
    check("R3 torpid", {7'b0, wake_out}, 8'h00);
  endtask

  task automatic t_drowsy;
    pm_awake = 0;
    wr(8'hF0, 8'h03);
    check("R3 drowsy", {7'b0, wake_out}, 8'h01);
    check("R4 pre", {7'b0, host_irq}, 8'h00);
    pm_awake = 1;
    @(negedge clk);
    check("R4 rise", {7'b0, host_irq}, 8'h01);
    rd_chk("R4 read", 8'hF1, 8'h01);
  endtask

  task automatic t_clear;
    wr(8'hF1, 8'h00);
    check("R5 zero", {7'b0, host_irq}, 8'h01);
    wr(8'hF1, 8'h01);
    check("R5 one", {7'b0, host_irq}, 8'h00);
    @(negedge clk); pm_awake = 0;
    @(negedge clk); pm_awake = 1;
    @(negedge clk);
    check("R5 re-rise", {7'b0, host_irq}, 8'h01);
    wr(8'hF0, 8'h01);
    check("R5 leave", {7'b0, host_irq}, 8'h00);
    wr(8'hF0, 8'h03);
    @(negedge clk);
    check("R5 discard", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_scratch;
    wr(8'hF2, 8'hA5);
    wr(8'hF3, 8'h3C);
    rd_chk("R6", 8'hF2, 8'hA5);
    rd_chk("R6", 8'hF3, 8'h3C);
    @(negedge clk); chip_wr_en = 1; chip_wr_sel = 0; chip_wr_data = 8'h77;
    @(negedge clk); chip_wr_sel = 1; chip_wr_data = 8'h88;
    @(negedge clk); chip_wr_en = 0;
    wr(8'hF4, 8'h00);
    wr(8'hF5, 8'h11);
    rd_chk("R7", 8'hF4, 8'h77);
    rd_chk("R7", 8'hF5, 8'h88);
  endtask

  task automatic t_ext;
    cccr_io_en = 7'b0000101;
    @(negedge clk);
    check("R8 flag", {1'b0, fn_reset_flag}, 8'h05);
    wr(8'hF6, 8'h02);
    check("R8 reenable", {1'b0, fn_reset_flag}, 8'h04);
    rd_chk("R8", 8'hF6, 8'h02);
    wr(8'hF6, 8'h0B);
    check("R8 all", {1'b0, fn_reset_flag}, 8'h00);
    rd_chk("R8 bit0", 8'hF6, 8'h0A);
  endtask

  task automatic t_fnrst;
    @(negedge clk); fn_rst = 7'b0000100;
    @(negedge clk); fn_rst = 0;
    check("R9 flag", {1'b0, fn_reset_flag}, 8'h04);
    rd_chk("R9", 8'hF6, 8'h02);
    rd_chk("R9 scr0", 8'hF2, 8'h00);
    rd_chk("R9 scr1", 8'hF3, 8'h00);
    @(negedge clk); fn_rst = 7'b0000001;
    host_wr_en = 1; host_addr = 8'hF6; host_wdata = 8'h0A;
    @(negedge clk); fn_rst = 0; host_wr_en = 0;
    check("R9 priority", {1'b0, fn_reset_flag}, 8'h01);
    rd_chk("R9 prio rd", 8'hF6, 8'h08);
  endtask

  task automatic t_undec;
    rd_chk("R10", 8'hF7, 8'h00);
    rd_chk("R10", 8'h00, 8'h00);
    rd_chk("R10", 8'hEF, 8'h00);
    rd_chk("R10 latency", 8'hF0, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_modes();
    t_drowsy();
    t_clear();
    t_scratch();
    t_ext();
    t_fnrst();
    t_undec();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule